// File: doc/BRIEF.md
# Watchpoint Event Down-Counter with Breakpoint Generation

This block counts debug watchpoint hits with two 16-bit down-counters. When a counter runs out, it asks for a breakpoint. Each counter is tied to exactly one event source: either one instruction watchpoint or one load/store watchpoint, picked through a per-counter configuration word. The block sits between the watchpoint comparators and the exception logic. Software loads a count, and the block then passes that many hits before it raises the request.

The kind of source decides where the break lands. An instruction source breaks before the matching instruction runs, so the hit that would take the count to zero is not committed and the counter keeps the value one. A load/store source breaks after the access completes, so the final decrement is committed and the counter holds zero. In masked mode, hits that arrive while the recoverable-interrupt status is low are dropped.

The trap enable used for each counter is the OR of two sets of bits. Privileged software writes one set through the register port. A debug host shifts the other set in serially and then applies it with an update strobe. Both sets can be read back together.

Top module: `wp_count_brk`

## Requirements
- R1: After reset, every counter, every configuration word and both trap enable sets are zero, both breakpoint outputs are low, and every read address returns zero.
- R2: A register write to address k (k below N_CNT) preloads counter k. Reading address k returns the counter's current value.
- R3: A counter whose configuration bit 1 is 1 (load/store source) drops by exactly one for each qualified hit. The hit that takes it from 1 to 0 raises bit k of `brk_post` for the one cycle after that hit, and the counter then reads 0.
- R4: A counter whose configuration bit 1 is 0 (instruction source) drops by one for each qualified hit while it is above 1. A qualified hit at value 1 raises bit k of `brk_pre` for the next cycle and leaves the counter at 1.
- R5: Address N_CNT+k holds the configuration of counter k: bit 0 activates the counter, bit 1 selects the source kind, and bits [2+IDX_W-1:2] give the watchpoint index. Hits on any other watchpoint, or on an inactive counter, have no effect.
- R6: While `mask_en` is 1 and `ri_status` is 0, hits neither decrement a counter nor raise a breakpoint. With `mask_en` at 0, hits count whatever `ri_status` is.
- R7: A counter at zero ignores hits and raises no breakpoint until it is written again.
- R8: A write to address 2*N_CNT loads the software trap enable bits from `wr_data[N_CNT-1:0]` only while `priv_user` is 0. Otherwise the write is ignored.
- R9: Each cycle with `dp_shift_en` high shifts `dp_shift_din` into a staging register, and the last bit shifted lands in bit 0. The debug-port enables change only when `dp_update` pulses, and they then copy the staging register.
- R10: A breakpoint for counter k is raised only if bit k of (software enables OR debug-port enables) was set in the hit cycle. A gated-off hit still updates the counter.
- R11: Reading address 2*N_CNT returns the software enables in bits [N_CNT-1:0] and the debug-port enables in bits [2*N_CNT-1:N_CNT].
- R12: A register write to a counter in the same cycle as a qualified hit loads the written value and raises no breakpoint.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| insn_wp_hit | input | N_IWP | One-cycle hit pulses from the instruction watchpoints |
| ldst_wp_hit | input | N_LWP | One-cycle hit pulses from the load/store watchpoints |
| ri_status | input | 1 | Recoverable-interrupt status |
| mask_en | input | 1 | Masked-mode enable |
| priv_user | input | 1 | 1 when the processor is in user mode |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | CNT_W | Register read data (combinational) |
| dp_shift_en | input | 1 | Debug-port shift enable |
| dp_shift_din | input | 1 | Debug-port serial data |
| dp_update | input | 1 | Applies the shifted bits to the debug-port enables |
| brk_pre | output | N_CNT | Pre-execution breakpoint pulses (instruction sources) |
| brk_post | output | N_CNT | Post-execution breakpoint pulses (load/store sources) |

## Verification
The assertions assume that every hit input is a one-cycle pulse sampled at the rising edge. They also assume that reads and writes follow the fixed address map, and that the configuration of a counter does not change in the same cycle as one of its hits. The stimulus drives hits for exactly one edge at a time and separates every configuration write from hit traffic by at least one idle cycle. The serial enables are shifted completely before `dp_update` is pulsed, so the enable state is always a defined word.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
   typedef enum logic {
      SRC_INSN = 1'b0,
      SRC_LDST = 1'b1
   } wpc_src_e;

   localparam int CFG_ACTIVE_BIT = 0;
   localparam int CFG_KIND_BIT   = 1;
   localparam int CFG_IDX_LSB    = 2;

   function automatic int wpc_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/wpc_event_qual.sv
module wpc_event_qual
   import wpc_pkg::*;
#(
   parameter int N_IWP = 4,
   parameter int N_LWP = 2,
   parameter int IDX_W = 2
) (
   input  logic [N_IWP-1:0] insn_hit_i,
   input  logic [N_LWP-1:0] ldst_hit_i,
   input  logic             active_i,
   input  wpc_src_e         kind_i,
   input  logic [IDX_W-1:0] idx_i,
   input  logic             mask_en_i,
   input  logic             ri_status_i,
   output logic             evt_o
);
   logic insn_sel;
   logic ldst_sel;
   logic blocked;

   always_comb begin
      insn_sel = 1'b0;
      for (int i = 0; i < N_IWP; i++) begin
         if (idx_i == IDX_W'(i)) insn_sel = insn_hit_i[i];
      end
   end

   always_comb begin
      ldst_sel = 1'b0;
      for (int j = 0; j < N_LWP; j++) begin
         if (idx_i == IDX_W'(j)) ldst_sel = ldst_hit_i[j];
      end
   end

   assign blocked = mask_en_i & ~ri_status_i;
   assign evt_o   = active_i & ~blocked &
                    ((kind_i == SRC_LDST) ? ldst_sel : insn_sel);
endmodule

// File: rtl/wpc_counter.sv
module wpc_counter
   import wpc_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             evt_i,
   input  wpc_src_e         kind_i,
   input  logic             te_eff_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             brk_pre_o,
   output logic             brk_post_o
);
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] ZERO = '0;

   logic [CNT_W-1:0] cnt_q;
   logic             pre_q;
   logic             post_q;
   logic             live_hit;
   logic             at_one;

   assign live_hit = evt_i & ~load_i & (cnt_q != ZERO);
   assign at_one   = (cnt_q == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= ZERO;
         pre_q  <= 1'b0;
         post_q <= 1'b0;
      end else begin
         pre_q  <= 1'b0;
         post_q <= 1'b0;
         if (load_i) begin
            cnt_q <= load_val_i;
         end else if (live_hit) begin
            if (kind_i == SRC_INSN && at_one) begin
               pre_q <= te_eff_i;
            end else begin
               cnt_q  <= cnt_q - ONE;
               post_q <= te_eff_i & at_one & (kind_i == SRC_LDST);
            end
         end
      end
   end

   assign cnt_o      = cnt_q;
   assign brk_pre_o  = pre_q;
   assign brk_post_o = post_q;

   // R7
   zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && cnt_q == ZERO) |=> (cnt_q == ZERO));

   // R3
   single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - ONE));

   // R3
   post_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      post_q |-> (cnt_q == ZERO));

   // R4
   pre_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pre_q |-> (cnt_q == ONE));

   // R10
   gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_q || post_q) |-> $past(te_eff_i));
endmodule

// File: rtl/wpc_te_regs.sv
module wpc_te_regs #(
   parameter int N_CNT = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sw_we_i,
   input  logic [N_CNT-1:0] sw_wdata_i,
   input  logic             priv_user_i,
   input  logic             sh_en_i,
   input  logic             sh_din_i,
   input  logic             sh_upd_i,
   output logic [N_CNT-1:0] sw_te_o,
   output logic [N_CNT-1:0] dp_te_o
);
   logic [N_CNT-1:0] sw_te_q;
   logic [N_CNT-1:0] dp_te_q;
   logic [N_CNT-1:0] stage_q;
   logic [N_CNT-1:0] stage_nxt;

   generate
      if (N_CNT == 1) begin : g_stage_bit
         assign stage_nxt = sh_din_i;
      end else begin : g_stage_shift
         assign stage_nxt = {stage_q[N_CNT-2:0], sh_din_i};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sw_te_q <= '0;
         dp_te_q <= '0;
         stage_q <= '0;
      end else begin
         if (sw_we_i && !priv_user_i) sw_te_q <= sw_wdata_i;
         if (sh_en_i)  stage_q <= stage_nxt;
         if (sh_upd_i) dp_te_q <= stage_q;
      end
   end

   assign sw_te_o = sw_te_q;
   assign dp_te_o = dp_te_q;

   // R8
   priv_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (priv_user_i || !sw_we_i) |=> $stable(sw_te_q));

   // R9
   dp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sh_upd_i) |=> $stable(dp_te_q));
endmodule

// File: rtl/wp_count_brk.sv
module wp_count_brk
   import wpc_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int N_CNT  = 2,
   parameter int N_IWP  = 4,
   parameter int N_LWP  = 2,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_IWP-1:0]  insn_wp_hit,
   input  logic [N_LWP-1:0]  ldst_wp_hit,
   input  logic              ri_status,
   input  logic              mask_en,
   input  logic              priv_user,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [CNT_W-1:0]  rd_data,
   input  logic              dp_shift_en,
   input  logic              dp_shift_din,
   input  logic              dp_update,
   output logic [N_CNT-1:0]  brk_pre,
   output logic [N_CNT-1:0]  brk_post
);
   localparam int MAX_WP  = wpc_max(N_IWP, N_LWP);
   localparam int IDX_W   = (MAX_WP < 2) ? 1 : $clog2(MAX_WP);
   localparam int CFG_W   = CFG_IDX_LSB + IDX_W;
   localparam int TE_ADDR = 2 * N_CNT;

   generate
      if (CNT_W < 2) begin : g_bad_cnt_w
         $error("CNT_W must be at least 2");
      end
      if (N_CNT < 1) begin : g_bad_n_cnt
         $error("N_CNT must be at least 1");
      end
      if (CFG_W > CNT_W || 2 * N_CNT > CNT_W) begin : g_bad_fit
         $error("configuration or enable word does not fit CNT_W");
      end
      if (TE_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
         $error("ADDR_W too small for the register map");
      end
   endgenerate

   logic [CFG_W-1:0] cfg_q [N_CNT];
   logic [CNT_W-1:0] cnt   [N_CNT];
   logic [N_CNT-1:0] sw_te;
   logic [N_CNT-1:0] dp_te;
   logic [N_CNT-1:0] te_eff;
   logic [N_CNT-1:0] evt;
   logic             te_we;

   assign te_we  = wr_en && (wr_addr == ADDR_W'(TE_ADDR));
   assign te_eff = sw_te | dp_te;

   wpc_te_regs #(.N_CNT(N_CNT)) u_te (
      .clk        (clk),
      .rst_n      (rst_n),
      .sw_we_i    (te_we),
      .sw_wdata_i (wr_data[N_CNT-1:0]),
      .priv_user_i(priv_user),
      .sh_en_i    (dp_shift_en),
      .sh_din_i   (dp_shift_din),
      .sh_upd_i   (dp_update),
      .sw_te_o    (sw_te),
      .dp_te_o    (dp_te)
   );

   generate
      for (genvar k = 0; k < N_CNT; k++) begin : g_ch
         logic     cnt_we;
         logic     cfg_we;
         wpc_src_e kind;

         assign cnt_we = wr_en && (wr_addr == ADDR_W'(k));
         assign cfg_we = wr_en && (wr_addr == ADDR_W'(N_CNT + k));
         assign kind   = wpc_src_e'(cfg_q[k][CFG_KIND_BIT]);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      cfg_q[k] <= '0;
            else if (cfg_we) cfg_q[k] <= wr_data[CFG_W-1:0];
         end

         wpc_event_qual #(.N_IWP(N_IWP), .N_LWP(N_LWP), .IDX_W(IDX_W)) u_qual (
            .insn_hit_i (insn_wp_hit),
            .ldst_hit_i (ldst_wp_hit),
            .active_i   (cfg_q[k][CFG_ACTIVE_BIT]),
            .kind_i     (kind),
            .idx_i      (cfg_q[k][CFG_IDX_LSB +: IDX_W]),
            .mask_en_i  (mask_en),
            .ri_status_i(ri_status),
            .evt_o      (evt[k])
         );

         wpc_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk        (clk),
            .rst_n      (rst_n),
            .load_i     (cnt_we),
            .load_val_i (wr_data),
            .evt_i      (evt[k]),
            .kind_i     (kind),
            .te_eff_i   (te_eff[k]),
            .cnt_o      (cnt[k]),
            .brk_pre_o  (brk_pre[k]),
            .brk_post_o (brk_post[k])
         );

         // R4
         pre_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
            brk_pre[k] |-> $past(cfg_q[k][CFG_KIND_BIT]) == 1'b0);

         // R3
         post_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
            brk_post[k] |-> $past(cfg_q[k][CFG_KIND_BIT]) == 1'b1);
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < N_CNT; k++) begin
         if (rd_addr == ADDR_W'(k))         rd_data = cnt[k];
         if (rd_addr == ADDR_W'(N_CNT + k)) rd_data = CNT_W'(cfg_q[k]);
      end
      if (rd_addr == ADDR_W'(TE_ADDR)) rd_data = CNT_W'({dp_te, sw_te});
   end

   // R6
   masked_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_en && !ri_status) |=> (brk_pre == '0 && brk_post == '0));
endmodule

// File: tb/test_wp_count_brk.sv
module test_wp_count_brk;
   localparam int CNT_W = 16;
   localparam int N_CNT = 2;
   localparam int N_IWP = 4;
   localparam int N_LWP = 2;
   localparam int AW    = 3;
   localparam logic [AW-1:0] A_TE = 3'd4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [N_IWP-1:0] iw = '0;
   logic [N_LWP-1:0] lw = '0;
   logic             ri = 1'b1, men = 1'b1, pu = 1'b0;
   logic             we = 1'b0;
   logic [AW-1:0]    wa = '0, ra = '0;
   logic [CNT_W-1:0] wd = '0;
   logic [CNT_W-1:0] rd;
   logic             se = 1'b0, sd = 1'b0, su = 1'b0;
   logic [N_CNT-1:0] bpre, bpost;

   int n_chk = 0;
   int n_err = 0;

   always #4 clk = ~clk;

   wp_count_brk #(.CNT_W(CNT_W), .N_CNT(N_CNT), .N_IWP(N_IWP), .N_LWP(N_LWP), .ADDR_W(AW))
   i_wp_count_brk (
      .clk(clk), .rst_n(rst_n), .insn_wp_hit(iw), .ldst_wp_hit(lw),
      .ri_status(ri), .mask_en(men), .priv_user(pu),
      .wr_en(we), .wr_addr(wa), .wr_data(wd), .rd_addr(ra), .rd_data(rd),
      .dp_shift_en(se), .dp_shift_din(sd), .dp_update(su),
      .brk_pre(bpre), .brk_post(bpost)
   );

   typedef struct packed {
      logic [3:0]  iw;
      logic [1:0]  lw;
      logic        ri;
      logic [15:0] c0;
      logic [15:0] c1;
      logic        post0;
      logic        pre1;
   } vec_t;

   // counter0: load/store idx1, counter1: instruction idx2, both start at 3
   localparam vec_t TBL [8] = '{
      '{4'b0100, 2'b10, 1'b1, 16'd2, 16'd2, 1'b0, 1'b0},
      '{4'b0001, 2'b01, 1'b1, 16'd2, 16'd2, 1'b0, 1'b0},
      '{4'b0100, 2'b10, 1'b0, 16'd2, 16'd2, 1'b0, 1'b0},
      '{4'b0100, 2'b00, 1'b1, 16'd2, 16'd1, 1'b0, 1'b0},
      '{4'b0000, 2'b10, 1'b1, 16'd1, 16'd1, 1'b0, 1'b0},
      '{4'b0100, 2'b10, 1'b1, 16'd0, 16'd1, 1'b1, 1'b1},
      '{4'b0100, 2'b10, 1'b1, 16'd0, 16'd1, 1'b0, 1'b1},
      '{4'b0000, 2'b00, 1'b1, 16'd0, 16'd1, 1'b0, 1'b0}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [CNT_W-1:0] d);
      @(negedge clk); we = 1'b1; wa = a; wd = d;
      @(negedge clk); we = 1'b0;
   endtask

   task automatic rdchk(input string req, input logic [AW-1:0] a, input logic [CNT_W-1:0] exp);
      ra = a; #1;
      check(req, 32'(rd), 32'(exp));
   endtask

   // drive hits for one edge, return at the following negedge
   task automatic hit(input logic [3:0] i, input logic [1:0] l);
      @(negedge clk); iw = i; lw = l;
      @(negedge clk); iw = '0; lw = '0;
   endtask

   task automatic shift_bit(input logic b);
      @(negedge clk); se = 1'b1; sd = b;
      @(negedge clk); se = 1'b0;
   endtask

   task automatic summary;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
   endtask

   initial begin
      #(8 * 100000);
      n_err++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      for (int a = 0; a <= 4; a++) rdchk("R1", AW'(a), '0);
      check("R1 brk", {bpre, bpost}, '0);
      rst_n = 1'b1;

      // R2 preload and readback
      wr(3'd0, 16'd3);
      wr(3'd1, 16'd3);
      rdchk("R2 c0", 3'd0, 16'd3);
      rdchk("R2 c1", 3'd1, 16'd3);
      wr(3'd2, 16'd7);   // active, ldst, idx1
      wr(3'd3, 16'd9);   // active, insn, idx2
      rdchk("R5 cfg", 3'd2, 16'd7);
      wr(A_TE, 16'd3);

      // table walk: R3 R4 R5 R6 R7
      for (int v = 0; v < 8; v++) begin
         @(negedge clk); iw = TBL[v].iw; lw = TBL[v].lw; ri = TBL[v].ri;
         @(negedge clk); iw = '0; lw = '0; ri = 1'b1;
         check("R3/R4 post", 32'(bpost), 32'({1'b0, TBL[v].post0}));
         check("R4/R3 pre",  32'(bpre),  32'({TBL[v].pre1, 1'b0}));
         rdchk("R3/R5/R6/R7 c0", 3'd0, TBL[v].c0);
         rdchk("R4/R5/R6 c1", 3'd1, TBL[v].c1);
      end
      check("R3 pulse one cycle", 32'(bpost), 0);

      // R6 unmasked counts with ri low
      wr(3'd0, 16'd5);
      men = 1'b0; ri = 1'b0;
      hit(4'b0000, 2'b10);
      rdchk("R6 unmasked", 3'd0, 16'd4);
      men = 1'b1; ri = 1'b1;

      // R12 write beats hit
      @(negedge clk); we = 1'b1; wa = 3'd0; wd = 16'd1; lw = 2'b10;
      @(negedge clk); we = 1'b0; lw = '0;
      rdchk("R12 load wins", 3'd0, 16'd1);
      check("R12 no brk", 32'(bpost), 0);

      // R8 / R9 / R11 enable registers
      wr(A_TE, 16'd0);
      rdchk("R8 sw clear", A_TE, 16'd0);
      shift_bit(1'b1);
      shift_bit(1'b0);
      rdchk("R9 before update", A_TE, 16'd0);
      @(negedge clk); su = 1'b1;
      @(negedge clk); su = 1'b0;
      rdchk("R9 R11 dp bits", A_TE, 16'h8);
      wr(A_TE, 16'd1);
      rdchk("R11 sw+dp", A_TE, 16'h9);
      pu = 1'b1;
      wr(A_TE, 16'd2);
      rdchk("R8 user write ignored", A_TE, 16'h9);
      pu = 1'b0;
      wr(A_TE, 16'd0);

      // R10 gating: c0 insn idx0 (sw=0, dp=0), c1 ldst idx0 (dp=1)
      wr(3'd2, 16'd1);
      wr(3'd3, 16'd3);
      wr(3'd0, 16'd1);
      wr(3'd1, 16'd1);
      @(negedge clk); iw = 4'b0001; lw = 2'b01;
      @(negedge clk); iw = '0; lw = '0;
      check("R10 gated pre", 32'(bpre), 0);
      check("R10 dp-only post", 32'(bpost), 32'h2);
      rdchk("R10 gated c0 holds", 3'd0, 16'd1);
      rdchk("R10 c1 zero", 3'd1, 16'd0);

      // R5 inactive counter ignores hits
      wr(3'd3, 16'd2);
      wr(3'd1, 16'd2);
      hit(4'b0000, 2'b01);
      rdchk("R5 inactive", 3'd1, 16'd2);

      summary();
   end
endmodule